// File: doc/BRIEF.md
# Single-Wire Sync Response Generator

This block is the target-side half of a speed-calibration handshake on a single-wire debug line. The block runs on the target debug clock and watches the incoming level of the line. A host asks for calibration by holding the line low much longer than any ordinary bit would. When the block sees such a low, it waits for the host to let the line rise. It then stays silent for a short guard interval so that the host can finish its own rising-edge drive. After that it pulls the line low for a fixed number of its own clock cycles, drives it high for exactly one cycle to sharpen the rising edge, and releases the line to high impedance.

The host times the low pulse and from it derives the target's clock rate for later traffic. Ordinary command decoding and bit transfer are handled elsewhere. While a response is in progress the block ignores the line completely. A request that arrives during that time has no effect.

The controller has six named states. ST_IDLE counts consecutive low samples. ST_WAIT_HIGH waits for the line to read high again. ST_GUARD holds off for the guard interval. ST_DRIVE_LOW drives the timing pulse. ST_SPEEDUP drives the single high cycle. ST_FINISH raises the status strobe for one cycle.

The transitions are:
- ST_IDLE→ST_WAIT_HIGH when the threshold is reached.
- ST_WAIT_HIGH→ST_GUARD when the line reads high.
- ST_GUARD→ST_DRIVE_LOW when the guard count runs out.
- ST_DRIVE_LOW→ST_SPEEDUP when the pulse count runs out.
- ST_SPEEDUP→ST_FINISH unconditionally.
- ST_FINISH→ST_IDLE unconditionally.

Top module: `sync_responder`

## Requirements
- R1: During reset and right after it, line_oe and sync_seen are 0.
- R2: A request is recognised once line_in has been sampled low on REQ_LOW_CYCLES (default 128) consecutive rising clock edges. Any low run shorter than that causes no drive and no sync_seen.
- R3: Low runs separated by even one high sample do not add up. Two runs of REQ_LOW_CYCLES-1 samples with a one-cycle high between them produce no response.
- R4: While line_in stays low after a request is recognised, line_oe stays 0, no matter how long the low lasts.
- R5: line_oe first rises right after the (GUARD_CYCLES+3)-th rising edge that follows line_in going high. That count is two synchroniser stages, one state step and GUARD_CYCLES (default 16) of guard.
- R6: The response drives line_oe=1 with line_out=0 for exactly PULSE_CYCLES (default 128) consecutive cycles.
- R7: Straight after the low pulse, line_oe=1 with line_out=1 for exactly one cycle. After that, line_oe returns to 0, so the line is driven for PULSE_CYCLES+1 cycles in total.
- R8: sync_seen is 1 for exactly one cycle, the cycle after the speedup cycle, and is 0 at every other time.
- R9: Activity on line_in between recognition and the return to ST_IDLE is ignored. Low samples from that interval do not count toward a new request, and no second response follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target debug clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Sensed level of the debug line (asynchronous) |
| line_out | output | 1 | Level driven onto the line when line_oe is 1 |
| line_oe | output | 1 | Drive enable for the line; 0 means high impedance |
| sync_seen | output | 1 | One-cycle strobe when a response has completed |

## Verification
The bench sweeps every low length from 1 to REQ_LOW_CYCLES-1 and checks that none of them triggers a response. A threshold that is off by one would answer the longest of these runs, and this sweep would catch it. The bench also tries lows at and beyond the threshold, including one three times as long. This exposes a design that starts driving before the host lets go of the line.

It measures the guard gap, the pulse length and the position of the speedup and strobe cycles to the exact clock. A wrong counter preload would shift each of these by one cycle. Two further cases cover the counting rules. One splits a long low with a single high sample, which catches a counter that fails to clear. The other holds the line low across the tail of the response, which catches detection that keeps counting while the block is busy and then produces a second response.

// File: rtl/sync_resp_pkg.sv
package sync_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_HIGH,
        ST_GUARD,
        ST_DRIVE_LOW,
        ST_SPEEDUP,
        ST_FINISH
    } resp_state_e;

    function automatic int unsigned count_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RESET_VAL;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RESET_VAL;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/low_timer.sv
module low_timer #(
    parameter int unsigned THRESH = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_s,
    output logic hit
);
    localparam int unsigned W = sync_resp_pkg::count_bits(THRESH);

    logic [W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!enable || line_s) begin
            run_q <= '0;
        end else if (run_q != W'(THRESH)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = enable && !line_s && (run_q >= W'(THRESH - 1));
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sync_responder.sv
module sync_responder #(
    parameter int unsigned REQ_LOW_CYCLES = 128,
    parameter int unsigned GUARD_CYCLES   = 16,
    parameter int unsigned PULSE_CYCLES   = 128,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out,
    output logic line_oe,
    output logic sync_seen
);
    import sync_resp_pkg::*;

    localparam int unsigned MAX_PHASE = (GUARD_CYCLES > PULSE_CYCLES) ? GUARD_CYCLES : PULSE_CYCLES;
    localparam int unsigned CW        = count_bits(MAX_PHASE);
    localparam logic [CW-1:0] GUARD_LOAD = CW'(GUARD_CYCLES - 1);
    localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYCLES - 1);

    resp_state_e state_q, state_d;
    logic        line_s;
    logic        req_hit;
    logic        ph_load;
    logic [CW-1:0] ph_val;
    logic        ph_zero;

    line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dout  (line_s)
    );

    low_timer #(.THRESH(REQ_LOW_CYCLES)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (state_q == ST_IDLE),
        .line_s (line_s),
        .hit    (req_hit)
    );

    phase_counter #(.W(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and phase counter loading
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_hit) state_d = ST_WAIT_HIGH;
            end
            ST_WAIT_HIGH: begin
                if (line_s) begin
                    state_d = ST_GUARD;
                    ph_load = 1'b1;
                    ph_val  = GUARD_LOAD;
                end
            end
            ST_GUARD: begin
                if (ph_zero) begin
                    state_d = ST_DRIVE_LOW;
                    ph_load = 1'b1;
                    ph_val  = PULSE_LOAD;
                end
            end
            ST_DRIVE_LOW: begin
                if (ph_zero) state_d = ST_SPEEDUP;
            end
            ST_SPEEDUP: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        line_oe   = 1'b0;
        line_out  = 1'b0;
        sync_seen = 1'b0;
        unique case (state_q)
            ST_DRIVE_LOW: line_oe = 1'b1;
            ST_SPEEDUP: begin
                line_oe  = 1'b1;
                line_out = 1'b1;
            end
            ST_FINISH: sync_seen = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sync_responder_chk.sv
module sync_responder_chk #(
    parameter int unsigned GUARD_CYCLES = 16,
    parameter int unsigned PULSE_CYCLES = 128
) (
    input logic clk,
    input logic rst_n,
    input logic line_oe,
    input logic line_out,
    input logic sync_seen
);
    localparam int unsigned RW = $clog2(PULSE_CYCLES + 2) + 1;
    localparam int unsigned QW = $clog2(GUARD_CYCLES + 2) + 1;

    logic [RW-1:0] run_cnt;
    logic [QW-1:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (line_oe && !line_out) begin
            if (run_cnt != {RW{1'b1}}) run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (line_oe) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt < QW'(GUARD_CYCLES)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out) |-> (run_cnt == RW'(PULSE_CYCLES)));

    assert_no_long_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out) |-> (run_cnt < RW'(PULSE_CYCLES)));

    assert_speedup_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out) |=> !line_oe);

    assert_seen_after_speedup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_seen |-> $past(line_oe && line_out));

    assert_seen_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_seen |=> !sync_seen);

    assert_guard_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> (quiet_cnt >= QW'(GUARD_CYCLES)));
endmodule

bind sync_responder sync_responder_chk #(
    .GUARD_CYCLES (GUARD_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_oe   (line_oe),
    .line_out  (line_out),
    .sync_seen (sync_seen)
);

// File: tb/tb_sync_responder.sv
module tb_sync_responder;
    localparam int REQ = 128;
    localparam int G   = 16;
    localparam int P   = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic line_out, line_oe, sync_seen;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sync_responder #(
        .REQ_LOW_CYCLES (REQ),
        .GUARD_CYCLES   (G),
        .PULSE_CYCLES   (P),
        .SYNC_STAGES    (2)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .line_out  (line_out),
        .line_oe   (line_oe),
        .sync_seen (sync_seen)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold line low for L sampled edges, release, then observe win cycles.
    // Optional disturbance: line low again at observation steps [ds, ds+dl).
    task automatic trial(input int L, input bit expect_resp, input int ds, input int dl, input int win);
        int first_oe = -1;
        int lowcnt = 0;
        int oecnt = 0;
        int spd_cnt = 0;
        int spd_k = -1;
        int seen_cnt = 0;
        int seen_k = -1;
        int rises = 0;
        int low_busy = 0;
        bit prev_oe = 1'b0;
        line_in = 1'b0;
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            if (line_oe || sync_seen) low_busy++;
        end
        line_in = 1'b1;
        for (int k = 1; k <= win; k++) begin
            @(negedge clk);
            if (line_oe && !prev_oe) rises++;
            if (line_oe && first_oe < 0) first_oe = k;
            if (line_oe) oecnt++;
            if (line_oe && !line_out) lowcnt++;
            if (line_oe && line_out) begin spd_cnt++; spd_k = k; end
            if (sync_seen) begin seen_cnt++; seen_k = k; end
            prev_oe = line_oe;
            line_in = !(k >= ds && k < ds + dl);
        end
        line_in = 1'b1;
        if (expect_resp) begin
            check(low_busy == 0, "R4 quiet during long low", low_busy, 0);
            check(first_oe == G + 3, "R5 guard gap", first_oe, G + 3);
            check(lowcnt == P, "R6 low pulse length", lowcnt, P);
            check(spd_cnt == 1, "R7 speedup count", spd_cnt, 1);
            check(spd_k == G + 3 + P, "R7 speedup position", spd_k, G + 3 + P);
            check(oecnt == P + 1, "R7 total drive cycles", oecnt, P + 1);
            check(seen_cnt == 1, "R8 strobe count", seen_cnt, 1);
            check(seen_k == G + 4 + P, "R8 strobe position", seen_k, G + 4 + P);
            check(rises == 1, "R9 single response", rises, 1);
        end else begin
            check(rises == 0 && low_busy == 0, "R2 short low ignored", rises + low_busy, 0);
            check(seen_cnt == 0, "R2 no strobe on short low", seen_cnt, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int busy;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(line_oe == 1'b0, "R1 oe in reset", int'(line_oe), 0);
        check(sync_seen == 1'b0, "R1 strobe in reset", int'(sync_seen), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(line_oe == 1'b0, "R1 oe after reset", int'(line_oe), 0);
        check(sync_seen == 1'b0, "R1 strobe after reset", int'(sync_seen), 0);

        // R2: sweep every sub-threshold length
        for (int L = 1; L < REQ; L++) trial(L, 1'b0, 0, 0, 40);

        // R2, R4..R8: at and beyond the threshold
        trial(REQ,     1'b1, 0, 0, G + P + 20);
        trial(REQ + 1, 1'b1, 0, 0, G + P + 20);
        trial(REQ + 7, 1'b1, 0, 0, G + P + 20);
        trial(3 * REQ, 1'b1, 0, 0, G + P + 20);

        // R3: split lows do not accumulate
        busy = 0;
        line_in = 1'b0;
        for (int i = 0; i < REQ - 1; i++) @(negedge clk);
        line_in = 1'b1;
        @(negedge clk);
        line_in = 1'b0;
        for (int i = 0; i < REQ - 1; i++) begin
            @(negedge clk);
            if (line_oe) busy++;
        end
        line_in = 1'b1;
        for (int i = 0; i < G + P + 20; i++) begin
            @(negedge clk);
            if (line_oe || sync_seen) busy++;
        end
        check(busy == 0, "R3 split lows ignored", busy, 0);

        // R9: long low during the response is ignored
        trial(REQ + 2, 1'b1, G + 13, 150, G + P + 13 + 150 + REQ + 40);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule